// File: doc/BRIEF.md
# Video Link Test Pattern Generator

This block drives a fixed test pattern onto the 24-bit RGB bus that feeds a serial video transmitter. It is used to measure power and signal integrity on the link without a real picture source. When the generator is enabled, every shift-clock cycle carries one pixel, the data-enable line is high, and both sync lines stay low. Red, green and blue always carry the same byte.

The block has two patterns. The toggle pattern (`TP_TOGGLE`) flips every bit of every colour on every cycle. Neighbouring bits always take opposite values, which gives the highest switching activity on the bus. The ramp pattern (`TP_RAMP`) runs a binary count of `RAMP_W` bits on the top bits of each colour and holds the lower bits at zero. This gives sixteen grey levels with the default widths. Bit 4 then toggles at half the clock rate, and each higher bit toggles at half the rate of the bit below it, down to one sixteenth of the clock rate for bit 7.

A three-state machine chooses the output. `TP_IDLE` drives a blank bus. The transitions are:
- `TP_IDLE` goes to `TP_TOGGLE` on enable with select low, or to `TP_RAMP` on enable with select high.
- `TP_TOGGLE` and `TP_RAMP` switch to each other when the select input changes while enable stays high.
- Any state returns to `TP_IDLE` when enable drops.

On every entry into a state, the shared pattern counter restarts from zero.

Top module: `tp_gen_top`

## Requirements
- R1: During reset and in the first cycle after it, `rgb_o` is 0, `de_o` is 0, and `hsync_o` and `vsync_o` are 0.
- R2: After an edge that samples `pat_en_i` low, the next cycle shows `rgb_o` = 0 and `de_o` = 0.
- R3: In toggle mode, bits 7, 5, 3 and 1 of each colour invert on every cycle. They are 0 in the first cycle after the mode is entered.
- R4: In toggle mode, bits 6, 4, 2 and 0 of each colour are the inverse of bits 7, 5, 3 and 1. So the first byte is 0x55, then 0xAA, and the two values alternate.
- R5: In ramp mode (`pat_sel_i` = 1), the top `RAMP_W` bits of each colour form a count. The count starts at 0 on entry, rises by one per cycle, and wraps from 15 to 0 with the default width.
- R6: In ramp mode, the low `CHAN_W-RAMP_W` bits of each colour (bits 3 to 0 by default) are 0.
- R7: The bus is laid out as red in `rgb_o[23:16]`, green in `[15:8]` and blue in `[7:0]`. All three bytes are equal in every cycle.
- R8: A change of `pat_en_i` or `pat_sel_i` takes effect in the cycle after the next clock edge, and the pattern restarts from its first value.
- R9: `de_o` is 1 in every cycle that shows a pattern. `hsync_o` and `vsync_o` are always 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Shift clock |
| rst_n | input | 1 | Active-low synchronous reset |
| pat_en_i | input | 1 | Pattern enable |
| pat_sel_i | input | 1 | Pattern select: 0 toggle, 1 ramp |
| rgb_o | output | 3*CHAN_W | Pixel bus: red, green, blue from the top down |
| de_o | output | 1 | Data enable |
| hsync_o | output | 1 | Horizontal sync, held low |
| vsync_o | output | 1 | Vertical sync, held low |

## Verification
The bench builds the block with `CHAN_W` = 8 and `RAMP_W` = 4. With these values the full sixteen-level ramp and its wrap back to zero come round within sixteen cycles, so a single directed hold covers them. Random runs of enable and select then produce every state transition, including mode switches in consecutive cycles. These short dwells test the restart from zero many times.

// File: rtl/tp_pkg.sv
package tp_pkg;

    typedef enum logic [1:0] {
        TP_IDLE   = 2'd0,
        TP_TOGGLE = 2'd1,
        TP_RAMP   = 2'd2
    } tp_state_e;

endpackage

// File: rtl/tp_fsm.sv
module tp_fsm
    import tp_pkg::*;
(
    input  logic      clk,
    input  logic      rst_n,
    input  logic      en_i,
    input  logic      sel_i,
    output tp_state_e state_o,
    output logic      restart_o,
    output logic      active_o
);

    tp_state_e state_q;
    tp_state_e state_d;

    // next-state selection
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            TP_IDLE: begin
                if (en_i) state_d = sel_i ? TP_RAMP : TP_TOGGLE;
            end
            TP_TOGGLE: begin
                if (!en_i)     state_d = TP_IDLE;
                else if (sel_i) state_d = TP_RAMP;
            end
            TP_RAMP: begin
                if (!en_i)      state_d = TP_IDLE;
                else if (!sel_i) state_d = TP_TOGGLE;
            end
            default: state_d = TP_IDLE;
        endcase
    end

    // state register
    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= TP_IDLE;
        else        state_q <= state_d;
    end

    // outputs
    always_comb begin
        state_o   = state_q;
        restart_o = (state_d != state_q);
        active_o  = (state_q != TP_IDLE);
    end

    // R2: an edge that sees enable low always lands in idle
    p_drop_to_idle_r2: assert property (@(posedge clk) disable iff (!rst_n)
        !en_i |=> state_q == TP_IDLE);

    // R8: the select takes effect on the next edge while enabled
    p_sel_follow_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (en_i && sel_i) |=> state_q == TP_RAMP);

endmodule

// File: rtl/tp_counter.sv
module tp_counter #(
    parameter int RAMP_W = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              restart_i,
    output logic [RAMP_W-1:0] cnt_o
);

    logic [RAMP_W-1:0] cnt_q;

    always_ff @(posedge clk) begin
        if (!rst_n)         cnt_q <= '0;
        else if (restart_i) cnt_q <= '0;
        else                cnt_q <= cnt_q + 1'b1;
    end

    assign cnt_o = cnt_q;

    // R8: a restart request always yields zero on the following cycle
    p_restart_zero_r8: assert property (@(posedge clk) disable iff (!rst_n)
        restart_i |=> cnt_q == '0);

endmodule

// File: rtl/tp_pixel_map.sv
module tp_pixel_map
    import tp_pkg::*;
#(
    parameter int CHAN_W = 8,
    parameter int RAMP_W = 4
) (
    input  tp_state_e         state_i,
    input  logic [RAMP_W-1:0] cnt_i,
    output logic [CHAN_W-1:0] pix_o
);

    localparam int LOW_W = CHAN_W - RAMP_W;

    logic [CHAN_W-1:0] toggle_pix;
    logic [CHAN_W-1:0] ramp_pix;
    logic              phase;

    assign phase = cnt_i[0];

    // odd bit positions follow the phase, even positions its inverse
    for (genvar b = 0; b < CHAN_W; b++) begin : g_toggle_bit
        if (b % 2 == 1) begin : g_odd
            assign toggle_pix[b] = phase;
        end else begin : g_even
            assign toggle_pix[b] = ~phase;
        end
    end

    if (LOW_W > 0) begin : g_ramp_pad
        assign ramp_pix = {cnt_i, {LOW_W{1'b0}}};
    end else begin : g_ramp_full
        assign ramp_pix = cnt_i[CHAN_W-1:0];
    end

    always_comb begin
        unique case (state_i)
            TP_TOGGLE: pix_o = toggle_pix;
            TP_RAMP:   pix_o = ramp_pix;
            TP_IDLE:   pix_o = '0;
            default:   pix_o = '0;
        endcase
    end

endmodule

// File: rtl/tp_gen_top.sv
module tp_gen_top
    import tp_pkg::*;
#(
    parameter int CHAN_W = 8,
    parameter int RAMP_W = 4
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                pat_en_i,
    input  logic                pat_sel_i,
    output logic [3*CHAN_W-1:0] rgb_o,
    output logic                de_o,
    output logic                hsync_o,
    output logic                vsync_o
);

    localparam int NUM_CHAN = 3;
    localparam int LOW_W    = CHAN_W - RAMP_W;

    tp_state_e         state;
    logic              restart;
    logic              active;
    logic [RAMP_W-1:0] cnt;
    logic [CHAN_W-1:0] pix;

    tp_fsm u_fsm (
        .clk      (clk),
        .rst_n    (rst_n),
        .en_i     (pat_en_i),
        .sel_i    (pat_sel_i),
        .state_o  (state),
        .restart_o(restart),
        .active_o (active)
    );

    tp_counter #(.RAMP_W(RAMP_W)) u_cnt (
        .clk      (clk),
        .rst_n    (rst_n),
        .restart_i(restart),
        .cnt_o    (cnt)
    );

    tp_pixel_map #(.CHAN_W(CHAN_W), .RAMP_W(RAMP_W)) u_map (
        .state_i(state),
        .cnt_i  (cnt),
        .pix_o  (pix)
    );

    for (genvar c = 0; c < NUM_CHAN; c++) begin : g_chan
        assign rgb_o[c*CHAN_W +: CHAN_W] = pix;
    end

    assign de_o    = active;
    assign hsync_o = 1'b0;
    assign vsync_o = 1'b0;

    logic [CHAN_W-1:0] red_b, grn_b, blu_b;
    assign red_b = rgb_o[2*CHAN_W +: CHAN_W];
    assign grn_b = rgb_o[CHAN_W +: CHAN_W];
    assign blu_b = rgb_o[0 +: CHAN_W];

    p_chan_equal_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (red_b == grn_b) && (grn_b == blu_b));

    p_blank_idle_r2: assert property (@(posedge clk) disable iff (!rst_n)
        !de_o |-> rgb_o == '0);

    p_sync_low_r9: assert property (@(posedge clk) disable iff (!rst_n)
        !hsync_o && !vsync_o);

    p_odd_flip_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (state == TP_TOGGLE && $past(state) == TP_TOGGLE) |-> blu_b[1] != $past(blu_b[1]));

    p_pair_differ_r4: assert property (@(posedge clk) disable iff (!rst_n)
        state == TP_TOGGLE |-> blu_b[1] != blu_b[0]);

    p_ramp_step_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (state == TP_RAMP && $past(state) == TP_RAMP)
        |-> blu_b[CHAN_W-1 -: RAMP_W] == $past(blu_b[CHAN_W-1 -: RAMP_W]) + 1'b1);

    if (LOW_W > 0) begin : g_low_chk
        p_ramp_low_zero_r6: assert property (@(posedge clk) disable iff (!rst_n)
            state == TP_RAMP |-> blu_b[LOW_W-1:0] == '0);
    end

    p_entry_first_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (state == TP_RAMP && $past(state) != TP_RAMP) |-> blu_b == '0);

endmodule

// File: tb/tp_gen_top_bench.sv
module tp_gen_top_bench;

    localparam int CLK_PERIOD = 10;
    localparam int CHAN_W     = 8;
    localparam int RAMP_W     = 4;

    logic                clk = 1'b0;
    logic                rst_n;
    logic                pat_en_i;
    logic                pat_sel_i;
    logic [3*CHAN_W-1:0] rgb_o;
    logic                de_o;
    logic                hsync_o;
    logic                vsync_o;

    int n_checks = 0;
    int n_errors = 0;
    bit done = 1'b0;

    // bench model: 0 idle, 1 toggle, 2 ramp
    int m_state = 0;
    int m_cnt   = 0;
    bit m_entry = 1'b0;

    always #(CLK_PERIOD/2) clk = ~clk;

    tp_gen_top #(.CHAN_W(CHAN_W), .RAMP_W(RAMP_W)) u_tp_gen_top (
        .clk      (clk),
        .rst_n    (rst_n),
        .pat_en_i (pat_en_i),
        .pat_sel_i(pat_sel_i),
        .rgb_o    (rgb_o),
        .de_o     (de_o),
        .hsync_o  (hsync_o),
        .vsync_o  (vsync_o)
    );

    function automatic logic [CHAN_W-1:0] exp_byte(int st, int cnt);
        logic [CHAN_W-1:0] v;
        v = '0;
        if (st == 1) begin
            v = (cnt % 2 == 0) ? 8'h55 : 8'hAA;
        end else if (st == 2) begin
            v = '0;
            v[CHAN_W-1 -: RAMP_W] = cnt[RAMP_W-1:0];
        end
        return v;
    endfunction

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_errors++;
            $display("FAIL %s: actual 0x%0h expected 0x%0h at %0t", req, act, exp, $time);
        end
    endtask

    task automatic model_edge(input bit en, input bit sel);
        int nxt;
        nxt = !en ? 0 : (sel ? 2 : 1);
        m_entry = (nxt != m_state);
        if (m_entry) m_cnt = 0;
        else         m_cnt = (m_cnt + 1) % (1 << RAMP_W);
        m_state = nxt;
    endtask

    task automatic check_cycle();
        logic [CHAN_W-1:0] e;
        logic [CHAN_W-1:0] b;
        e = exp_byte(m_state, m_cnt);
        b = rgb_o[CHAN_W-1:0];
        if (m_state == 0)      check("R2 blank", {8'h0, rgb_o}, 32'h0);
        else if (m_state == 1) check("R3 toggle byte", {24'h0, b}, {24'h0, e});
        else                   check("R5 ramp byte", {24'h0, b}, {24'h0, e});
        check("R7 red==blue", {24'h0, rgb_o[23:16]}, {24'h0, b});
        check("R7 green==blue", {24'h0, rgb_o[15:8]}, {24'h0, b});
        if (m_state == 1) check("R4 even inverse", {28'h0, b[6], b[4], b[2], b[0]},
                                {28'h0, ~b[7], ~b[5], ~b[3], ~b[1]});
        if (m_state == 2) check("R6 low bits", {28'h0, b[3:0]}, 32'h0);
        if (m_entry && m_state != 0) check("R8 restart", {24'h0, b}, {24'h0, exp_byte(m_state, 0)});
        check("R9 de", {31'h0, de_o}, {31'h0, (m_state != 0)});
        check("R9 syncs", {30'h0, hsync_o, vsync_o}, 32'h0);
    endtask

    task automatic step(input bit en, input bit sel);
        pat_en_i  = en;
        pat_sel_i = sel;
        @(posedge clk);
        model_edge(en, sel);
        @(negedge clk);
        check_cycle();
    endtask

    initial begin
        int seed_dummy;
        seed_dummy = $urandom(32'h1234_5678);
        rst_n = 1'b0;
        pat_en_i = 1'b0;
        pat_sel_i = 1'b0;
        repeat (3) @(posedge clk);
        @(negedge clk);
        check("R1 reset rgb", {8'h0, rgb_o}, 32'h0);
        check("R1 reset de", {31'h0, de_o}, 32'h0);
        check("R1 reset syncs", {30'h0, hsync_o, vsync_o}, 32'h0);
        rst_n = 1'b1;
        @(posedge clk);
        @(negedge clk);
        check("R1 after reset rgb", {8'h0, rgb_o}, 32'h0);
        // directed: toggle run, ramp run with wrap, quick switches
        repeat (6)  step(1'b1, 1'b0);
        repeat (20) step(1'b1, 1'b1);
        step(1'b1, 1'b0);
        step(1'b1, 1'b1);
        step(1'b0, 1'b1);
        step(1'b1, 1'b1);
        step(1'b0, 1'b0);
        // constrained random: dwell lengths 1..20
        for (int k = 0; k < 120; k++) begin
            bit en, sel;
            int len;
            en  = ($urandom % 4) != 0;
            sel = $urandom % 2;
            len = 1 + ($urandom % 20);
            for (int j = 0; j < len; j++) step(en, sel);
        end
        done = 1'b1;
        $display("Simulation finished: %0d checks, %0d errors", n_checks, n_errors);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            n_checks++;
            n_errors++;
            $display("FAIL watchdog: actual hung expected finish");
            $display("Simulation finished: %0d checks, %0d errors", n_checks, n_errors);
            $finish;
        end
    end

endmodule